// File: doc/BRIEF.md
# Power-of-Two Clock Output Divider

This block derives a clock for an output pin from a single input clock. A chain of sixteen divide-by-two stages runs from the input clock, and a 4-bit select value picks one stage so that the output runs at the input frequency divided by 2^(N+1). Select 0 gives half the input frequency, and select 15 divides by 65536.

An enable starts the chain. When the enable is cleared, the output does not stop at once. The chain keeps running until the selected stage is low, and then it holds there, so the output ends on a full low phase without a runt pulse.

Two configuration bits can replace the divided clock. A bypass bit sends the input clock straight to the output. A second select bit sends an externally generated 1 Hz tick clock to the output, and this bit takes priority over the bypass bit. There is no streaming data path, so all pins are plain control and clock signals.

Top module: `clkout_pow2_div`

## Requirements
- R1: While `rst_ni` is low, the divider chain is cleared to zero and the divided output path drives `clk_o` low.
- R2: With `enable_i` high, `bypass_i` = 0 and `tick_sel_i` = 0, `clk_o` is a square wave with a period of 2^(N+1) input cycles. It is high for 2^N cycles and low for 2^N cycles, where N is the unsigned value of `sel_i`.
- R3: After reset with the chain at zero, once `enable_i` is raised, `clk_o` first rises after exactly 2^N rising edges of `clk_i`.
- R4: When `enable_i` is cleared while the selected stage is high, the chain keeps advancing until that stage falls. `clk_o` goes low within 2^N cycles.
- R5: When `enable_i` is low and the selected stage is low, the chain holds its value and `clk_o` stays low for as long as the enable remains low.
- R6: Raising `enable_i` again after a completed stop resumes counting from the held value. `clk_o` then rises after 2^N cycles.
- R7: With `bypass_i` = 1 and `tick_sel_i` = 0, `clk_o` follows `clk_i` directly.
- R8: With `tick_sel_i` = 1, `clk_o` follows `tick_i`, whatever the value of `bypass_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Start the chain (1) or request a clean stop (0) |
| sel_i | input | 4 | Stage select N; output frequency is Fin/2^(N+1) |
| bypass_i | input | 1 | Send `clk_i` directly to `clk_o` |
| tick_sel_i | input | 1 | Send `tick_i` to `clk_o`; overrides bypass |
| tick_i | input | 1 | External 1 Hz tick clock |
| clk_o | output | 1 | Output clock for the pin |

## Verification
The assertions assume that `sel_i`, `bypass_i` and `tick_sel_i` are quasi-static. They change only when the clock is low and away from any edge. They also assume that `tick_i` does not move in the same instant as an edge of `clk_i`. The stimulus follows these assumptions: it changes `sel_i` only while reset is held, and it drives every input a few nanoseconds after a falling edge. The bench checks the counting, stop and resume sequences against a behavioural cycle model, and it checks each path-selection case at both clock phases.

// File: rtl/clkout_div_pkg.sv
package clkout_div_pkg;

  // Number of divide-by-two stages used when no override is given.
  localparam int unsigned DEF_STAGES = 16;

  // Source that drives the output pin.
  typedef enum logic [1:0] {
    PATH_DIV    = 2'd0,
    PATH_BYPASS = 2'd1,
    PATH_TICK   = 2'd2
  } out_path_e;

  function automatic out_path_e pick_path(input logic bypass, input logic tick_sel);
    if (tick_sel)    return PATH_TICK;
    else if (bypass) return PATH_BYPASS;
    else             return PATH_DIV;
  endfunction

endpackage

// File: rtl/clkout_chain.sv
// Toggle-stage chain: stage k flips when every lower stage is high and the chain advances.
module clkout_chain #(
  parameter int unsigned STAGES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              advance_i,
  output logic [STAGES-1:0] count_o
);

  logic [STAGES:0]   carry;
  logic [STAGES-1:0] stage_q;

  assign carry[0] = advance_i;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    assign carry[k+1] = carry[k] & stage_q[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       stage_q[k] <= 1'b0;
      else if (carry[k]) stage_q[k] <= ~stage_q[k];
    end
  end

  assign count_o = stage_q;

endmodule

// File: rtl/clkout_tap_sel.sv
// Binary mux tree that picks one stage of the chain.
module clkout_tap_sel #(
  parameter int unsigned STAGES = 16,
  parameter int unsigned SEL_W  = $clog2(STAGES)
) (
  input  logic [STAGES-1:0] count_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              tap_o
);

  localparam int unsigned LEAVES = 1 << SEL_W;

  // Level l of the tree holds LEAVES >> l nodes.
  logic [LEAVES-1:0] lvl [SEL_W+1];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < STAGES) begin : g_real
      assign lvl[0][i] = count_i[i];
    end else begin : g_pad
      assign lvl[0][i] = 1'b0;
    end
  end

  for (genvar l = 0; l < SEL_W; l++) begin : g_lvl
    for (genvar n = 0; n < LEAVES; n++) begin : g_node
      if (n < (LEAVES >> (l + 1))) begin : g_mux
        assign lvl[l+1][n] = sel_i[l] ? lvl[l][2*n+1] : lvl[l][2*n];
      end else begin : g_unused
        assign lvl[l+1][n] = 1'b0;
      end
    end
  end

  assign tap_o = lvl[SEL_W][0];

endmodule

// File: rtl/clkout_stop_ctl.sv
// The chain runs while enabled, and after enable drops it keeps running until the selected tap is low.
module clkout_stop_ctl (
  input  logic enable_i,
  input  logic tap_i,
  output logic advance_o
);

  always_comb begin
    advance_o = enable_i | tap_i;
  end

endmodule

// File: rtl/clkout_path_mux.sv
module clkout_path_mux
  import clkout_div_pkg::*;
(
  input  logic clk_i,
  input  logic div_i,
  input  logic tick_i,
  input  logic bypass_i,
  input  logic tick_sel_i,
  output logic clk_o
);

  out_path_e path;

  always_comb begin
    path = pick_path(bypass_i, tick_sel_i);
    case (path)
      PATH_TICK:   clk_o = tick_i;
      PATH_BYPASS: clk_o = clk_i;
      PATH_DIV:    clk_o = div_i;
      default:     clk_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/clkout_pow2_div.sv
module clkout_pow2_div #(
  parameter int unsigned STAGES = clkout_div_pkg::DEF_STAGES,
  localparam int unsigned SEL_W = $clog2(STAGES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             bypass_i,
  input  logic             tick_sel_i,
  input  logic             tick_i,
  output logic             clk_o
);

  logic [STAGES-1:0] count_q;
  logic              tap_w;
  logic              advance_w;

  clkout_chain #(.STAGES(STAGES)) chain_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .advance_i(advance_w),
    .count_o  (count_q)
  );

  clkout_tap_sel #(.STAGES(STAGES), .SEL_W(SEL_W)) tap_i (
    .count_i(count_q),
    .sel_i  (sel_i),
    .tap_o  (tap_w)
  );

  clkout_stop_ctl stop_i (
    .enable_i (enable_i),
    .tap_i    (tap_w),
    .advance_o(advance_w)
  );

  clkout_path_mux mux_i (
    .clk_i     (clk_i),
    .div_i     (tap_w),
    .tick_i    (tick_i),
    .bypass_i  (bypass_i),
    .tick_sel_i(tick_sel_i),
    .clk_o     (clk_o)
  );

endmodule

// File: rtl/clkout_div_chk.sv
module clkout_div_chk #(
  parameter int unsigned STAGES = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              bypass_i,
  input logic              tick_sel_i,
  input logic              tick_i,
  input logic              clk_o,
  input logic [STAGES-1:0] count,
  input logic              tap
);

  localparam logic [STAGES-1:0] ONE = STAGES'(1);

  // R1: the chain sits at zero through reset and on release
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (count == '0));

  // R2: while enabled the chain advances by one on every edge
  assert_run_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |=> (count == $past(count) + ONE));

  // R4: a high tap keeps the chain advancing after enable drops
  assert_finish_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && tap) |=> (count == $past(count) + ONE));

  // R5: a completed stop freezes the chain and keeps the tap low
  assert_park_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !tap) |=> ($stable(count) && !tap));

  // R7: the bypass path is low just before a rising input edge
  assert_bypass_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_i && !tick_sel_i) |-> !clk_o);

  // R7: the bypass path is high just before a falling input edge
  assert_bypass_high_R7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (bypass_i && !tick_sel_i) |-> clk_o);

  // R8: the tick path has priority and copies the tick input
  assert_tick_path_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_sel_i |-> (clk_o == tick_i));

endmodule

bind clkout_pow2_div clkout_div_chk #(.STAGES(STAGES)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .enable_i  (enable_i),
  .bypass_i  (bypass_i),
  .tick_sel_i(tick_sel_i),
  .tick_i    (tick_i),
  .clk_o     (clk_o),
  .count     (count_q),
  .tap       (tap_w)
);

// File: tb/clkout_pow2_div_tb_top.sv
`timescale 1ns/1ps
module clkout_pow2_div_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enable_i = 1'b0;
  logic [3:0] sel_i = 4'd0;
  logic       bypass_i = 1'b0;
  logic       tick_sel_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       clk_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;
  int unsigned ref_cnt = 0;

  always #10 clk_i = ~clk_i;

  clkout_pow2_div dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable_i),
    .sel_i     (sel_i),
    .bypass_i  (bypass_i),
    .tick_sel_i(tick_sel_i),
    .tick_i    (tick_i),
    .clk_o     (clk_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model of the chain: an integer counter.
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_cnt = 0;
    else if (enable_i || ((ref_cnt >> sel_i) & 1) != 0) ref_cnt = (ref_cnt + 1) % 65536;
  end

  // Compare the output against the model in every low phase.
  always begin
    @(negedge clk_i);
    #1;
    if (!done) begin
      int exp;
      if (tick_sel_i)    exp = int'(tick_i);
      else if (bypass_i) exp = 0;
      else if (!rst_ni)  exp = 0;
      else               exp = int'((ref_cnt >> sel_i) & 1);
      check(clk_o == exp[0], "R2 R4 R5 cycle model", int'(clk_o), exp);
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", cycles, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic drive_gap();
    @(negedge clk_i);
    #3;
  endtask

  // Count low phases until clk_o reaches lvl.
  task automatic wait_level(input logic lvl, input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      #1;
      n++;
    end while (clk_o !== lvl && n < limit);
  endtask

  task automatic do_reset(input logic [3:0] sel);
    drive_gap();
    rst_ni = 1'b0;
    enable_i = 1'b0;
    sel_i = sel;
    repeat (2) drive_gap();
    rst_ni = 1'b1;
  endtask

  initial begin
    int n;
    int half;
    // R1: output low while in reset
    repeat (3) drive_gap();
    check(clk_o == 1'b0, "R1 reset low", int'(clk_o), 0);
    rst_ni = 1'b1;

    // R2 and R3 for each select value
    for (int s = 0; s < 16; s++) begin
      half = 1 << s;
      do_reset(4'(s));
      enable_i = 1'b1;
      wait_level(1'b1, half + 4, n);
      check(n == half, "R3 first rise", n, half);
      if (s <= 14) begin
        wait_level(1'b0, half + 4, n);
        check(n == half, "R2 high width", n, half);
      end
      if (s <= 13) begin
        wait_level(1'b1, half + 4, n);
        check(n == half, "R2 low width", n, half);
      end
    end

    // R4, R5, R6: clean stop and resume with select 3
    do_reset(4'd3);
    enable_i = 1'b1;
    wait_level(1'b1, 20, n);
    repeat (3) drive_gap();
    enable_i = 1'b0;
    wait_level(1'b0, 20, n);
    check(n <= 8, "R4 stop within half period", n, 8);
    begin
      int highs = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk_i);
        #1;
        if (clk_o) highs++;
      end
      check(highs == 0, "R5 parked low", highs, 0);
    end
    drive_gap();
    enable_i = 1'b1;
    wait_level(1'b1, 20, n);
    check(n == 8, "R6 resume rise", n, 8);

    // R5: disable while the tap is already low
    wait_level(1'b0, 20, n);
    drive_gap();
    enable_i = 1'b0;
    repeat (30) drive_gap();
    check(clk_o == 1'b0, "R5 stop while low", int'(clk_o), 0);

    // R7: bypass follows the input clock in both phases
    bypass_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_i);
      #5;
      check(clk_o == 1'b1, "R7 bypass high phase", int'(clk_o), 1);
      @(negedge clk_i);
      #5;
      check(clk_o == 1'b0, "R7 bypass low phase", int'(clk_o), 0);
    end

    // R8: tick path overrides bypass
    drive_gap();
    tick_sel_i = 1'b1;
    tick_i = 1'b1;
    @(posedge clk_i);
    #5;
    check(clk_o == 1'b1, "R8 tick high over bypass", int'(clk_o), 1);
    drive_gap();
    tick_i = 1'b0;
    @(posedge clk_i);
    #5;
    check(clk_o == 1'b0, "R8 tick low over bypass", int'(clk_o), 0);
    drive_gap();
    bypass_i = 1'b0;
    tick_i = 1'b1;
    @(posedge clk_i);
    #5;
    check(clk_o == 1'b1, "R8 tick without bypass", int'(clk_o), 1);
    drive_gap();
    tick_sel_i = 1'b0;
    tick_i = 1'b0;
    repeat (4) drive_gap();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule